// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Sequencer

This block is a slave on an 8-bit utility bus and sits in front of a pair of cascaded legacy interrupt controllers. Those controllers hand over a vector only after two separate acknowledge pulses. A processor that wants the vector issues one ordinary read to a dedicated address. The sequencer decodes that read and pulls the channel-ready line low at once, so the bus master waits. It then drives the two acknowledge pulses with a programmed width and spacing, and captures the byte the controller places on its data lines during the second pulse. After one settle clock it releases channel-ready, and the captured vector is the read data.

A read to any other address leaves the sequencer idle. The bus then behaves as if the block were absent. If the read strobe is withdrawn part-way through, the sequencer does not cut off the pulse in progress. It completes that pulse, returns to idle and lets the channel run again. The captured vector stays on the read data while the strobe is held and is cleared one clock after the strobe drops.

The reset is asynchronous and active low, and the block releases it internally in step with the clock. All outputs come from flip-flops.

Top module: `intack_sequencer`

## Requirements
- R1: While reset is asserted, and for the clocks of internal reset release that follow, the acknowledge output is high, channel-ready is high and the read data is zero.
- R2: On the first clock edge at which the read strobe is high and the address equals the vector address (default 16'h04C0), channel-ready goes low.
- R3: A decoded vector read produces exactly two active-low acknowledge pulses. Each is low for PULSE_LEN clocks (default 4), and they are separated by GAP_LEN high clocks (default 2). The first pulse starts on the same edge at which channel-ready falls.
- R4: Channel-ready stays low for 2*PULSE_LEN+GAP_LEN+1 clocks, which covers both pulses plus one settle clock. It then returns high while the strobe is still held.
- R5: The read data takes the controller data sampled on the last clock of the second pulse. It shows that value from the settle clock onward, and data present during the first pulse is never captured.
- R6: While the strobe stays high after completion, the read data holds the vector and no further pulses occur. One clock after the strobe drops, the read data is zero.
- R7: A read to any address other than the vector address produces no acknowledge pulse, keeps channel-ready high and keeps the read data at zero.
- R8: If the strobe drops during an acknowledge pulse, that pulse still lasts its full PULSE_LEN clocks. Channel-ready returns high on the edge that ends the pulse, no later pulse follows, and nothing is captured.
- R9: If the strobe drops during the gap between the pulses, channel-ready returns high on the next clock edge and the second pulse is never issued.
- R10: After a completed read and release of the strobe, a new vector read starts a fresh two-pulse sequence and returns the new vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (16) | Bus address |
| bus_rd | input | 1 | Read strobe, active high |
| ctrl_data | input | DATA_W (8) | Data lines from the interrupt controller |
| ack_n | output | 1 | Interrupt acknowledge pulse to the controller, active low |
| chan_rdy | output | 1 | Channel-ready to the bus master; low stretches the cycle |
| rd_data | output | DATA_W (8) | Read data returned to the processor |

## Verification
A sequencer stuck in or skipping a state shows up at the ports within one pulse length. The symptoms are a missing or extra acknowledge pulse, a pulse of the wrong width, or channel-ready rising before the settle clock. The bench records every output on every clock of each transaction and compares the three traces against patterns derived from the requirements. Any pattern mismatch is therefore reported for the transaction in which it occurs. A capture on the wrong clock is caught as soon as channel-ready rises, because the controller model drives the vector only during the second pulse.

// File: rtl/intack_pkg.sv
package intack_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACK1 = 3'd1,
    ST_GAP  = 3'd2,
    ST_ACK2 = 3'd3,
    ST_HOLD = 3'd4,
    ST_DONE = 3'd5
  } seq_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/intack_rst_sync.sv
module intack_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/intack_decode.sv
module intack_decode #(
  parameter int unsigned        ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]  VEC_ADDR = 16'h04C0
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  output logic              vec_hit
);

  assign vec_hit = bus_rd && (bus_addr == VEC_ADDR);

endmodule

// File: rtl/intack_timer.sv
module intack_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || en) begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/intack_vlatch.sv
module intack_vlatch #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              clr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (clr) begin
      dout <= '0;
    end else if (cap) begin
      dout <= din;
    end
  end

endmodule

// File: rtl/intack_fsm.sv
module intack_fsm
  import intack_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4,
  parameter int unsigned GAP_LEN   = 2,
  parameter int unsigned CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vec_hit,
  input  logic             bus_rd,
  input  logic [CNT_W-1:0] cnt,
  output seq_state_t       state_q,
  output logic             cnt_clr,
  output logic             cnt_en,
  output logic             cap_en,
  output logic             vec_clr,
  output logic             ack_n_q,
  output logic             rdy_q
);

  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_LEN - 1);
  localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_LEN - 1);

  seq_state_t state_d;
  logic       abort_q;
  logic       abort_d;
  logic       pulse_end;
  logic       gap_end;
  logic       in_pulse;
  logic       ack_n_d;
  logic       rdy_d;

  assign pulse_end = (cnt == PULSE_LAST);
  assign gap_end   = (cnt == GAP_LAST);
  assign in_pulse  = (state_q == ST_ACK1) || (state_q == ST_ACK2);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (vec_hit) state_d = ST_ACK1;
      end
      ST_ACK1: begin
        if (pulse_end) state_d = (abort_q || !bus_rd) ? ST_IDLE : ST_GAP;
      end
      ST_GAP: begin
        if (!bus_rd)      state_d = ST_IDLE;
        else if (gap_end) state_d = ST_ACK2;
      end
      ST_ACK2: begin
        if (pulse_end) state_d = (abort_q || !bus_rd) ? ST_IDLE : ST_HOLD;
      end
      ST_HOLD: begin
        state_d = bus_rd ? ST_DONE : ST_IDLE;
      end
      ST_DONE: begin
        if (!bus_rd) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // A strobe loss inside a pulse is remembered until that pulse ends.
  assign abort_d = in_pulse && (state_d == state_q) && (abort_q || !bus_rd);

  assign cnt_clr = (state_d != state_q);
  assign cnt_en  = in_pulse || (state_q == ST_GAP);
  assign cap_en  = (state_q == ST_ACK2) && (state_d == ST_HOLD);
  assign vec_clr = (state_d == ST_IDLE);

  assign ack_n_d = !((state_d == ST_ACK1) || (state_d == ST_ACK2));
  assign rdy_d   = !((state_d == ST_ACK1) || (state_d == ST_GAP) ||
                     (state_d == ST_ACK2) || (state_d == ST_HOLD));

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      abort_q <= 1'b0;
      ack_n_q <= 1'b1;
      rdy_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      abort_q <= abort_d;
      ack_n_q <= ack_n_d;
      rdy_q   <= rdy_d;
    end
  end

endmodule

// File: rtl/intack_sequencer.sv
module intack_sequencer
  import intack_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 16,
  parameter int unsigned       DATA_W      = 8,
  parameter logic [ADDR_W-1:0] VEC_ADDR    = 16'h04C0,
  parameter int unsigned       PULSE_LEN   = 4,
  parameter int unsigned       GAP_LEN     = 2,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] ctrl_data,
  output logic              ack_n,
  output logic              chan_rdy,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned CNT_MAX = max2(PULSE_LEN, GAP_LEN);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  initial begin
    if (PULSE_LEN < 1) $error("PULSE_LEN must be at least 1");
    if (GAP_LEN < 2)   $error("GAP_LEN must be at least 2");
    if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
  end

  logic             rst_sync_n;
  logic             vec_hit;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr;
  logic             cnt_en;
  logic             cap_en;
  logic             vec_clr;
  seq_state_t       state_q;

  intack_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  intack_decode #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_dec (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .vec_hit  (vec_hit)
  );

  intack_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .cnt   (cnt)
  );

  intack_fsm #(.PULSE_LEN(PULSE_LEN), .GAP_LEN(GAP_LEN), .CNT_W(CNT_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .vec_hit (vec_hit),
    .bus_rd  (bus_rd),
    .cnt     (cnt),
    .state_q (state_q),
    .cnt_clr (cnt_clr),
    .cnt_en  (cnt_en),
    .cap_en  (cap_en),
    .vec_clr (vec_clr),
    .ack_n_q (ack_n),
    .rdy_q   (chan_rdy)
  );

  intack_vlatch #(.DATA_W(DATA_W)) u_vl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cap   (cap_en),
    .clr   (vec_clr),
    .din   (ctrl_data),
    .dout  (rd_data)
  );

endmodule

// File: rtl/intack_chk.sv
module intack_chk
  import intack_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 8,
  parameter logic [ADDR_W-1:0] VEC_ADDR  = 16'h04C0,
  parameter int unsigned       PULSE_LEN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              ack_n,
  input logic              chan_rdy,
  input logic [DATA_W-1:0] rd_data,
  input seq_state_t        state_q
);

  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (!ack_n) begin
      low_run <= low_run + 16'd1;
    end else begin
      low_run <= '0;
    end
  end

  // R2
  rdy_drop_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && bus_rd && bus_addr == VEC_ADDR) |=> !chan_rdy);

  // R3
  ack_inside_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> !chan_rdy);

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> (low_run == 16'(PULSE_LEN)));

  // R7
  other_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !(bus_rd && bus_addr == VEC_ADDR)) |=> (chan_rdy && ack_n));

  // R6
  vector_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && bus_rd) |=> $stable(rd_data));

  // R6
  vector_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && !bus_rd) |=> (rd_data == '0));

endmodule

bind intack_sequencer intack_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .VEC_ADDR  (VEC_ADDR),
  .PULSE_LEN (PULSE_LEN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .ack_n    (ack_n),
  .chan_rdy (chan_rdy),
  .rd_data  (rd_data),
  .state_q  (state_q)
);

// File: tb/sim_intack_sequencer.sv
module sim_intack_sequencer;

  localparam int          P   = 4;
  localparam int          G   = 2;
  localparam logic [15:0] VEC = 16'h04C0;
  localparam int          N   = 2*P + G + 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_rd;
  logic [7:0]  ctrl_data;
  logic        ack_n;
  logic        chan_rdy;
  logic [7:0]  rd_data;

  int checks = 0;
  int fails  = 0;
  logic [7:0] cur_vec = 8'h00;
  int pulse_no = 0;
  logic [7:0] exp_q[$];
  logic prev_rdy = 1'b1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intack_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .ctrl_data(ctrl_data), .ack_n(ack_n), .chan_rdy(chan_rdy), .rd_data(rd_data)
  );

  // Controller model: the vector is on the lines only during the second pulse.
  always @(negedge ack_n) pulse_no = pulse_no + 1;
  always @(posedge chan_rdy) pulse_no = 0;
  assign ctrl_data = (!ack_n && pulse_no == 2) ? cur_vec : 8'hC3;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: a completed vector read is seen when ready rises under the strobe.
  always @(negedge clk) begin
    if (rst_n && !prev_rdy && chan_rdy && bus_rd) begin
      if (exp_q.size() == 0) begin
        check("R5", "unexpected completion", 32'(rd_data), 32'hFFFF);
      end else begin
        check("R5", "vector returned", 32'(rd_data), 32'(exp_q.pop_front()));
      end
    end
    prev_rdy = chan_rdy;
  end

  // drop < 0: strobe kept through the trace. Otherwise the strobe falls after sample index drop.
  task automatic run_seq(input logic [7:0] vec, input logic [15:0] adr, input int drop,
                         input string rq_ack, input string rq_rdy, input string rq_dat);
    bit   hit = (adr == VEC);
    int   bad_a = -1, bad_r = -1, bad_d = -1;
    logic act_a = 1'b1, exp_a = 1'b1, act_r = 1'b1, exp_r = 1'b1;
    logic [7:0] act_d = '0, exp_d = '0;
    cur_vec = vec;
    if (hit && drop < 0) exp_q.push_back(vec);
    bus_addr = adr;
    bus_rd   = 1'b1;
    for (int i = 0; i < N; i++) begin
      logic ea, er;
      logic [7:0] ed;
      @(negedge clk);
      ea = 1'b1; er = 1'b1; ed = '0;
      if (hit) begin
        if (drop < 0) begin
          ea = !(i < P || (i >= P+G && i < 2*P+G));
          er = !(i < 2*P+G+1);
          ed = (i >= 2*P+G) ? vec : 8'h00;
        end else if (drop < P) begin
          ea = !(i < P);
          er = !(i < P);
        end else if (drop < P+G) begin
          ea = !(i < P);
          er = !(i < drop+1);
        end else begin
          ea = !(i < P || (i >= P+G && i < 2*P+G));
          er = !(i < 2*P+G);
        end
      end
      if (ack_n !== ea && bad_a < 0) begin bad_a = i; act_a = ack_n; exp_a = ea; end
      if (chan_rdy !== er && bad_r < 0) begin bad_r = i; act_r = chan_rdy; exp_r = er; end
      if (rd_data !== ed && bad_d < 0) begin bad_d = i; act_d = rd_data; exp_d = ed; end
      if (i == drop) bus_rd = 1'b0;
    end
    check(rq_ack, $sformatf("ack_n at cycle %0d", bad_a), 32'(act_a), 32'(exp_a));
    check(rq_rdy, $sformatf("chan_rdy at cycle %0d", bad_r), 32'(act_r), 32'(exp_r));
    check(rq_dat, $sformatf("rd_data at cycle %0d", bad_d), 32'(act_d), 32'(exp_d));
    if (bus_rd) begin
      bus_rd = 1'b0;
      @(negedge clk);
      check("R6", "rd_data after strobe drop", 32'(rd_data), 32'h0);
      check("R6", "chan_rdy after strobe drop", 32'(chan_rdy), 32'h1);
    end
    bus_addr = 16'h0000;
    @(negedge clk);
  endtask

  initial begin
    rst_n    = 1'b0;
    bus_addr = 16'h0000;
    bus_rd   = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "ack_n in reset", 32'(ack_n), 32'h1);
    check("R1", "chan_rdy in reset", 32'(chan_rdy), 32'h1);
    check("R1", "rd_data in reset", 32'(rd_data), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "chan_rdy after release", 32'(chan_rdy), 32'h1);

    // R2 R3 R4 R5 R6: complete vector read
    run_seq(8'h5A, VEC, -1, "R3", "R2/R4", "R5");
    // R10: fresh read with a different vector
    run_seq(8'hA7, VEC, -1, "R10", "R10", "R10");
    // R7: other addresses pass through
    run_seq(8'h11, 16'h04C1, -1, "R7", "R7", "R7");
    run_seq(8'h22, 16'h0000, -1, "R7", "R7", "R7");
    // R8: abort during first pulse, and during second pulse
    run_seq(8'h33, VEC, 1, "R8", "R8", "R8");
    run_seq(8'h44, VEC, P+G+1, "R8", "R8", "R8");
    // R9: abort in the gap
    run_seq(8'h55, VEC, P, "R9", "R9", "R9");
    // R10: normal read after aborts
    run_seq(8'h0F, VEC, -1, "R10", "R10", "R10");

    check("R5", "pending scoreboard entries", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule